// File: doc/BRIEF.md
# Vector Register Move Unit

This block is the data-movement and bitwise-logic datapath of a small SIMD register file. The file holds eight 128-bit vector registers. Each accepted request names an operation, a destination register, a source register, and a flag that says whether the source is a memory operand. A memory operand arrives on a 128-bit data bus together with its byte address. For 64-bit loads the value sits in bits 63:0 of that bus, and for 32-bit scalar loads it sits in bits 31:0.

Every operation finishes in one clock. The block merges the new data into the correct part of the destination register. Depending on the operation, the rest of the register is either kept or cleared. One cycle after the request, the block shows the full new destination value on a completion bus.

Full-width aligned moves and the three bitwise operations need a 16-byte-aligned address when their source is memory. If such a request has a misaligned address, the block raises a one-cycle fault pulse and writes nothing. Memory access, arithmetic and instruction decoding are handled elsewhere.

Top module: `vreg_move_unit`

## Requirements
- R1: A synchronous reset clears all eight registers to zero and holds `doneValid`, `alignFault` and `reqReady` low. After reset, reading any register (see R10: AND of a register with itself) returns zero.
- R2: Opcode 0 (aligned full move) writes the 128-bit source into the destination. The source is register `reqSrc` when `reqSrcMem`=0 and `reqMemData` when `reqSrcMem`=1. In the cycle after acceptance, `doneValid`=1, `doneDst` is the destination index and `doneData` is the new value.
- R3: Opcode 1 (unaligned full move) gives the same result as opcode 0 for any address and never raises `alignFault`.
- R4: Opcode 2 (low-half load) always takes its source from memory. It writes `reqMemData[63:0]` into destination bits 63:0, keeps bits 127:64, ignores `reqMemData[127:64]`, and never faults.
- R5: Opcode 3 (high-half load) always takes its source from memory. It writes `reqMemData[63:0]` into destination bits 127:64, keeps bits 63:0, and never faults.
- R6: Opcode 4 copies bits 127:64 of register `reqSrc` into destination bits 63:0 and keeps destination bits 127:64.
- R7: Opcode 5 copies bits 63:0 of register `reqSrc` into destination bits 127:64 and keeps destination bits 63:0.
- R8: Opcode 6 with `reqSrcMem`=1 writes `reqMemData[31:0]` into destination bits 31:0 and zeroes bits 127:32.
- R9: Opcode 6 with `reqSrcMem`=0 writes bits 31:0 of register `reqSrc` into destination bits 31:0 and keeps bits 127:32.
- R10: Opcodes 7, 8 and 9 write the bitwise AND, OR and XOR of the destination and the source over all 128 bits back into the destination.
- R11: For opcodes 0, 7, 8 and 9 with `reqSrcMem`=1 and `reqAddr[3:0]`≠0, `alignFault` is 1 in the next cycle, `doneValid` is 0, and the destination is unchanged. With a register source, the address is ignored.
- R12: Opcodes 10 to 15 write nothing and raise neither `doneValid` nor `alignFault`.
- R13: `reqReady` is high from the first cycle after reset. A new request can be accepted every cycle, and each request sees the results of all earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqOp | input | 4 | Operation code |
| reqDst | input | 3 | Destination register index |
| reqSrc | input | 3 | Source register index |
| reqSrcMem | input | 1 | Source is the memory operand |
| reqAddr | input | 32 | Byte address of the memory operand |
| reqMemData | input | 128 | Memory operand data |
| doneValid | output | 1 | A register was written last cycle |
| doneDst | output | 3 | Index of the written register |
| doneData | output | 128 | New value of the written register |
| alignFault | output | 1 | Last request was rejected for misalignment |

## Verification
A corrupted register is never visible on its own. It shows up on `doneData` one cycle after any later operation that reads it as destination or source, so the bench re-reads registers through a self-AND after every corner case. A wrong merge rule or a wrong lane selection shows up one cycle after the faulty request, as a mismatch in a half or a 32-bit lane of `doneData`. A missed or spurious alignment check shows up in that same cycle as a wrong `alignFault` or `doneValid`. A write that wrongly went through is caught by the next read of that destination.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MOVA = 4'd0,
    OP_MOVU = 4'd1,
    OP_LDLO = 4'd2,
    OP_LDHI = 4'd3,
    OP_HTOL = 4'd4,
    OP_LTOH = 4'd5,
    OP_MOVS = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9
  } vmuOp_e;

  typedef enum logic [2:0] {
    MG_FULL,
    MG_LO64,
    MG_HI64,
    MG_LO32Z,
    MG_LO32K,
    MG_AND,
    MG_OR,
    MG_XOR
  } vmuMerge_e;

  typedef struct packed {
    logic      wrEn;
    logic      useMem;
    logic      takeHigh;
    vmuMerge_e merge;
  } vmuStrobe_t;

endpackage

// File: rtl/vmu_ctrl.sv
module vmu_ctrl
  import vmu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [OP_W-1:0]   reqOp,
  input  logic              reqSrcMem,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output vmuStrobe_t        strobe,
  output logic              alignFault
);

  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic fire;
  logic known;
  logic needAlign;
  logic misaligned;
  logic faultNow;

  assign fire       = reqValid & reqReady;
  assign misaligned = |reqAddr[ALIGN_LSB-1:0];

  always_comb begin
    known           = 1'b1;
    needAlign       = 1'b0;
    strobe.useMem   = reqSrcMem;
    strobe.takeHigh = 1'b0;
    strobe.merge    = MG_FULL;
    case (vmuOp_e'(reqOp))
      OP_MOVA: needAlign = 1'b1;
      OP_MOVU: needAlign = 1'b0;
      OP_LDLO: begin
        strobe.useMem = 1'b1;
        strobe.merge  = MG_LO64;
      end
      OP_LDHI: begin
        strobe.useMem = 1'b1;
        strobe.merge  = MG_HI64;
      end
      OP_HTOL: begin
        strobe.useMem   = 1'b0;
        strobe.takeHigh = 1'b1;
        strobe.merge    = MG_LO64;
      end
      OP_LTOH: begin
        strobe.useMem = 1'b0;
        strobe.merge  = MG_HI64;
      end
      OP_MOVS: strobe.merge = reqSrcMem ? MG_LO32Z : MG_LO32K;
      OP_AND: begin
        needAlign    = 1'b1;
        strobe.merge = MG_AND;
      end
      OP_OR: begin
        needAlign    = 1'b1;
        strobe.merge = MG_OR;
      end
      OP_XOR: begin
        needAlign    = 1'b1;
        strobe.merge = MG_XOR;
      end
      default: known = 1'b0;
    endcase
    faultNow    = fire & known & needAlign & strobe.useMem & misaligned;
    strobe.wrEn = fire & known & ~faultNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqReady   <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      reqReady   <= 1'b1;
      alignFault <= faultNow;
    end
  end

endmodule

// File: rtl/vmu_datapath.sv
module vmu_datapath
  import vmu_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  vmuStrobe_t       strobe,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [VEC_W-1:0] memData,
  output logic [VEC_W-1:0] dstOld,
  output logic [VEC_W-1:0] srcOld,
  output logic             doneValid,
  output logic [IDX_W-1:0] doneDst,
  output logic [VEC_W-1:0] doneData
);

  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0]  regView [NUM_REGS];
  logic [VEC_W-1:0]  operand;
  logic [HALF_W-1:0] lane64;
  logic [VEC_W-1:0]  newVal;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [VEC_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (strobe.wrEn && dstIdx == IDX_W'(g)) begin
        q <= newVal;
      end
    end
    assign regView[g] = q;
  end

  // two read ports: destination (for merges) and source
  assign dstOld = regView[dstIdx];
  assign srcOld = regView[srcIdx];

  assign operand = strobe.useMem ? memData : srcOld;
  assign lane64  = strobe.takeHigh ? operand[VEC_W-1:HALF_W] : operand[HALF_W-1:0];

  always_comb begin
    case (strobe.merge)
      MG_LO64:  newVal = {dstOld[VEC_W-1:HALF_W], lane64};
      MG_HI64:  newVal = {lane64, dstOld[HALF_W-1:0]};
      MG_LO32Z: newVal = {{(VEC_W-SCALAR_W){1'b0}}, operand[SCALAR_W-1:0]};
      MG_LO32K: newVal = {dstOld[VEC_W-1:SCALAR_W], operand[SCALAR_W-1:0]};
      MG_AND:   newVal = dstOld & operand;
      MG_OR:    newVal = dstOld | operand;
      MG_XOR:   newVal = dstOld ^ operand;
      default:  newVal = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneValid <= 1'b0;
      doneDst   <= '0;
      doneData  <= '0;
    end else begin
      doneValid <= strobe.wrEn;
      if (strobe.wrEn) begin
        doneDst  <= dstIdx;
        doneData <= newVal;
      end
    end
  end

endmodule

// File: rtl/vreg_move_unit.sv
module vreg_move_unit
  import vmu_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int VEC_W       = 128,
  parameter int SCALAR_W    = 32,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 16,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [OP_W-1:0]   reqOp,
  input  logic [IDX_W-1:0]  reqDst,
  input  logic [IDX_W-1:0]  reqSrc,
  input  logic              reqSrcMem,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [VEC_W-1:0]  reqMemData,
  output logic              doneValid,
  output logic [IDX_W-1:0]  doneDst,
  output logic [VEC_W-1:0]  doneData,
  output logic              alignFault
);

  vmuStrobe_t       strobe;
  logic [VEC_W-1:0] dstOld;
  logic [VEC_W-1:0] srcOld;

  vmu_ctrl #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BYTES(ALIGN_BYTES)
  ) ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqSrcMem (reqSrcMem),
    .reqAddr   (reqAddr),
    .reqReady  (reqReady),
    .strobe    (strobe),
    .alignFault(alignFault)
  );

  vmu_datapath #(
    .NUM_REGS(NUM_REGS),
    .VEC_W   (VEC_W),
    .SCALAR_W(SCALAR_W)
  ) dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dstIdx   (reqDst),
    .srcIdx   (reqSrc),
    .memData  (reqMemData),
    .dstOld   (dstOld),
    .srcOld   (srcOld),
    .doneValid(doneValid),
    .doneDst  (doneDst),
    .doneData (doneData)
  );

endmodule

// File: rtl/vmu_checker.sv
module vmu_checker
  import vmu_pkg::*;
#(
  parameter int VEC_W       = 128,
  parameter int SCALAR_W    = 32,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [OP_W-1:0]   reqOp,
  input logic              reqSrcMem,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [VEC_W-1:0]  reqMemData,
  input logic [VEC_W-1:0]  dstOld,
  input logic [VEC_W-1:0]  srcOld,
  input logic              doneValid,
  input logic [VEC_W-1:0]  doneData,
  input logic              alignFault
);

  localparam int HALF_W    = VEC_W / 2;
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic fire;
  logic needsAlign;
  assign fire       = reqValid && reqReady;
  assign needsAlign = (reqOp == OP_MOVA) || (reqOp == OP_AND) ||
                      (reqOp == OP_OR) || (reqOp == OP_XOR);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!doneValid && !alignFault));

  assert_low_load_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && reqOp == OP_LDLO) |=>
      (doneValid && doneData[VEC_W-1:HALF_W] == $past(dstOld[VEC_W-1:HALF_W]) &&
       doneData[HALF_W-1:0] == $past(reqMemData[HALF_W-1:0])));

  assert_high_to_low_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && reqOp == OP_HTOL) |=>
      (doneValid && doneData[HALF_W-1:0] == $past(srcOld[VEC_W-1:HALF_W]) &&
       doneData[VEC_W-1:HALF_W] == $past(dstOld[VEC_W-1:HALF_W])));

  assert_scalar_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && reqOp == OP_MOVS && reqSrcMem) |=>
      (doneValid && doneData[VEC_W-1:SCALAR_W] == '0));

  assert_align_fault_R11: assert property (@(posedge clk) disable iff (rst)
    (fire && needsAlign && reqSrcMem && (|reqAddr[ALIGN_LSB-1:0])) |=>
      (alignFault && !doneValid));

  assert_undefined_op_R12: assert property (@(posedge clk) disable iff (rst)
    (fire && reqOp > OP_XOR) |=> (!doneValid && !alignFault));

  assert_fault_excl_R11: assert property (@(posedge clk) disable iff (rst)
    alignFault |-> !doneValid);

endmodule

bind vreg_move_unit vmu_checker #(
  .VEC_W      (VEC_W),
  .SCALAR_W   (SCALAR_W),
  .ADDR_W     (ADDR_W),
  .ALIGN_BYTES(ALIGN_BYTES)
) chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqOp     (reqOp),
  .reqSrcMem (reqSrcMem),
  .reqAddr   (reqAddr),
  .reqMemData(reqMemData),
  .dstOld    (dstOld),
  .srcOld    (srcOld),
  .doneValid (doneValid),
  .doneData  (doneData),
  .alignFault(alignFault)
);

// File: tb/vreg_move_unit_test.sv
`timescale 1ns/1ps
module vreg_move_unit_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         reqValid;
  logic         reqReady;
  logic [3:0]   reqOp;
  logic [2:0]   reqDst;
  logic [2:0]   reqSrc;
  logic         reqSrcMem;
  logic [31:0]  reqAddr;
  logic [127:0] reqMemData;
  logic         doneValid;
  logic [2:0]   doneDst;
  logic [127:0] doneData;
  logic         alignFault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [127:0] refRegs [8];

  always #2.5 clk = ~clk;

  vreg_move_unit uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqDst(reqDst), .reqSrc(reqSrc), .reqSrcMem(reqSrcMem),
    .reqAddr(reqAddr), .reqMemData(reqMemData), .doneValid(doneValid),
    .doneDst(doneDst), .doneData(doneData), .alignFault(alignFault)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'(seed * 32'h9E37_79B1 + i * 32'h0101_1357);
    return v;
  endfunction

  // behavioural model of one request
  task automatic issue(input string req, input int op, input int dst, input int src,
                       input bit mem, input logic [31:0] addr, input logic [127:0] data);
    logic [127:0] d, s, v;
    bit wr, flt;
    d = refRegs[dst];
    s = mem ? data : refRegs[src];
    wr = 1; flt = 0; v = '0;
    case (op)
      0, 1: v = s;
      2:    v = {d[127:64], data[63:0]};
      3:    v = {data[63:0], d[63:0]};
      4:    v = {d[127:64], refRegs[src][127:64]};
      5:    v = {refRegs[src][63:0], d[63:0]};
      6:    v = mem ? {96'd0, data[31:0]} : {d[127:32], refRegs[src][31:0]};
      7:    v = d & s;
      8:    v = d | s;
      9:    v = d ^ s;
      default: wr = 0;
    endcase
    if ((op == 0 || op == 7 || op == 8 || op == 9) && mem && addr[3:0] != 4'd0) begin
      flt = 1; wr = 0;
    end
    reqValid = 1; reqOp = 4'(op); reqDst = 3'(dst); reqSrc = 3'(src);
    reqSrcMem = mem; reqAddr = addr; reqMemData = data;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    check(req, "doneValid", 128'(doneValid), 128'(wr));
    check(req, "alignFault", 128'(alignFault), 128'(flt));
    if (wr) begin
      check(req, "doneDst", 128'(doneDst), 128'(dst));
      check(req, "doneData", doneData, v);
      refRegs[dst] = v;
    end
  endtask

  task automatic peek(input string req, input int idx);
    issue(req, 7, idx, idx, 0, 32'd0, '0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) refRegs[i] = '0;
    rst = 1; reqValid = 0; reqOp = '0; reqDst = '0; reqSrc = '0;
    reqSrcMem = 0; reqAddr = '0; reqMemData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13", "reqReady in reset", 128'(reqReady), 128'd0);
    check("R1", "doneValid in reset", 128'(doneValid), 128'd0);
    rst = 0;
    @(negedge clk);
    check("R1", "doneValid after reset", 128'(doneValid), 128'd0);
    check("R1", "alignFault after reset", 128'(alignFault), 128'd0);
    check("R13", "reqReady after reset", 128'(reqReady), 128'd1);
    for (int i = 0; i < 8; i++) peek("R1", i);

    issue("R2", 0, 1, 0, 1, 32'h100, pattern(1));
    issue("R2", 0, 2, 1, 0, 32'h7, '0);
    issue("R3", 1, 3, 0, 1, 32'h103, pattern(2));
    issue("R3", 1, 4, 3, 0, 32'h9, '0);
    issue("R3", 1, 5, 0, 1, 32'h1F, pattern(3));
    issue("R3", 1, 6, 0, 1, 32'h2, pattern(4));
    issue("R3", 1, 7, 0, 1, 32'h0, pattern(5));

    issue("R4", 2, 1, 0, 1, 32'h1, pattern(6));
    issue("R5", 3, 2, 0, 1, 32'h5, pattern(7));
    issue("R6", 4, 4, 5, 0, 32'h0, '0);
    issue("R7", 5, 5, 6, 0, 32'h0, '0);
    issue("R8", 6, 6, 0, 1, 32'h3, pattern(8));
    issue("R9", 6, 7, 1, 0, 32'h0, '0);
    issue("R9", 6, 3, 3, 0, 32'h0, '0);

    issue("R10", 7, 1, 2, 0, 32'h0, '0);
    issue("R10", 8, 2, 3, 0, 32'h0, '0);
    issue("R10", 9, 3, 5, 0, 32'h0, '0);
    issue("R10", 7, 4, 0, 1, 32'h40, pattern(9));
    issue("R10", 8, 5, 0, 1, 32'h50, pattern(10));
    issue("R10", 9, 6, 0, 1, 32'h60, pattern(11));

    issue("R11", 0, 2, 0, 1, 32'h108, pattern(12));
    peek("R11", 2);
    issue("R11", 9, 3, 0, 1, 32'h4, pattern(13));
    issue("R11", 7, 4, 0, 1, 32'h1, '0);
    issue("R11", 8, 5, 0, 1, 32'hF, pattern(14));
    peek("R11", 3);
    peek("R11", 4);
    issue("R11", 0, 0, 7, 0, 32'h10F, '0);
    issue("R11", 8, 6, 1, 0, 32'h3, '0);

    issue("R12", 10, 1, 2, 1, 32'h0, pattern(15));
    issue("R12", 15, 1, 2, 0, 32'h0, pattern(16));
    peek("R12", 1);

    issue("R13", 1, 0, 0, 1, 32'h0, pattern(17));
    issue("R13", 9, 0, 0, 1, 32'h0, pattern(18));
    issue("R13", 8, 0, 0, 1, 32'h0, pattern(19));
    for (int i = 0; i < 8; i++) peek("R13", i);

    @(negedge clk);
    check("R13", "idle doneValid", 128'(doneValid), 128'd0);
    check("R13", "idle alignFault", 128'(alignFault), 128'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule